// File: doc/BRIEF.md
# USB Device Token and Handshake Responder

This block decides how a full-speed USB device function answers each packet the host sends. A packet receiver hands it a one-cycle summary of every packet: the byte count (PID and CRC included), the PID byte and the two bytes that follow. The block classifies the packet and compares the token address with the active device address. It keeps the most recent SETUP or OUT token, and answers with one of four actions. It can store a DATA packet into the free half of a double-buffered receive area, reply with a handshake PID, return a handshake that software parked in an endpoint's transmit length field, or ask the packet transmitter to send a prepared IN buffer.

Software talks to the block through three small register paths. It writes the receive length (writing zero frees the buffer), writes one transmit length field per IN endpoint, and writes a new device address. A transmit length field holds either a byte count (bit 4 clear) or a handshake PID (bit 4 set). After a buffer is sent, the field falls back to NAK straight away. A new address is held pending. It becomes active only when the transmitter reports that a buffer packet has finished, so the status stage of an address assignment still goes out under the old address.

Top module: `usb_token_responder`

## Requirements
- R1: After reset, tx_req is 0, dev_addr is 0, cur_tok is 0, rx_data_len is 0, rx_data_tok is 0, rx_half is 0, and every transmit length field holds NAK (0x5A).
- R2: For a packet of 3 or more bytes whose PID is SETUP (0x2D), OUT (0xE1) or IN (0x69), the address is rx_byte1[6:0]. If it differs from dev_addr, cur_tok becomes 0 and no reply is requested.
- R3: A SETUP or OUT token with a matching address sets cur_tok to its PID and requests no reply. The exception is an OUT with rx_byte1[7]=1 (endpoint 1), which sets cur_tok to 0xFF.
- R4: A DATA0 (0xC3) or DATA1 (0x4B) packet arriving while cur_tok is 0 requests no reply and changes no stored state.
- R5: A DATA packet arriving while cur_tok is nonzero and rx_data_len, read as signed, is greater than 0 is answered with NAK (0x5A). rx_data_len, rx_data_tok and rx_half stay unchanged.
- R6: A DATA packet that would otherwise be accepted but has fewer than 4 bytes is answered with ACK (0xD2). rx_data_len, rx_data_tok and rx_half stay unchanged.
- R7: Any other DATA packet with cur_tok nonzero loads rx_data_len with its byte count and rx_data_tok with cur_tok, toggles rx_half, and is answered with ACK.
- R8: A matching IN token is answered with NAK while rx_data_len, read as signed, is greater than 0.
- R9: A matching IN token selects transmit field 0 when rx_byte1[7]=0. With rx_byte1[7]=1 it selects field 1 when rx_byte2[0]=0 and field 2 when rx_byte2[0]=1. The chosen index appears on tx_buf_sel.
- R10: If the selected field has bit 4 set, a handshake request (tx_is_buf=0) carries that field as tx_pid. Otherwise a buffer request (tx_is_buf=1) carries the field on tx_buf_len, and the field is set to NAK so that the next IN to it gets a NAK handshake.
- R11: tx_req is a single-cycle pulse that is raised in the cycle after rx_valid is sampled.
- R12: A written address becomes dev_addr on the tx_done that ends a buffer request. A tx_done that ends a handshake leaves dev_addr unchanged.
- R13: A packet shorter than 3 bytes is ignored: there is no reply and cur_tok is unchanged. A packet of 3 or more bytes with any other non-DATA PID sets cur_tok to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | One-cycle strobe: packet summary valid |
| rx_len | input | 8 | Received byte count, PID and CRC included |
| rx_pid | input | 8 | PID byte |
| rx_byte1 | input | 8 | Byte after PID (address, low endpoint bit) |
| rx_byte2 | input | 8 | Third byte (bit 0 selects the second interrupt endpoint) |
| txlen_wr | input | 1 | Write strobe for a transmit length field |
| txlen_sel | input | 2 | Field index to write |
| txlen_wdata | input | 8 | Byte count or handshake PID |
| rx_len_wr | input | 1 | Write strobe for the receive length |
| rx_len_wdata | input | 8 | New receive length (0 frees the buffer) |
| addr_wr | input | 1 | Write strobe for a new device address |
| addr_wdata | input | 7 | New device address |
| tx_done | input | 1 | Transmitter finished the last requested packet |
| tx_req | output | 1 | One-cycle transmit request |
| tx_is_buf | output | 1 | 1: send buffer, 0: send handshake |
| tx_pid | output | 8 | Handshake PID for a handshake request |
| tx_buf_sel | output | 2 | Transmit buffer index |
| tx_buf_len | output | 8 | Byte count of the buffer to send |
| rx_data_len | output | 8 | Stored receive length (signed) |
| rx_data_tok | output | 8 | Token under which the data was stored |
| rx_half | output | 1 | Receive buffer half to be filled next |
| dev_addr | output | 7 | Active device address |
| cur_tok | output | 8 | Current SETUP/OUT token, 0 when none |

## Verification
The assertions assume that rx_valid is a single-cycle strobe with a gap of at least one idle cycle between strobes. They also assume that tx_done comes only after a request and that software writes never fall in the cycle where a packet is dispatched. The bench drives every packet as an isolated one-cycle strobe on the falling clock edge and pulses tx_done only after a reply. It makes its register writes in cycles with no packet, so register writes never collide with the dispatch updates that take priority over them.

// File: rtl/usbtr_pkg.sv
package usbtr_pkg;
  localparam logic [7:0] PID_SETUP = 8'h2D;
  localparam logic [7:0] PID_OUT   = 8'hE1;
  localparam logic [7:0] PID_IN    = 8'h69;
  localparam logic [7:0] PID_DATA0 = 8'hC3;
  localparam logic [7:0] PID_DATA1 = 8'h4B;
  localparam logic [7:0] PID_ACK   = 8'hD2;
  localparam logic [7:0] PID_NAK   = 8'h5A;
  localparam logic [7:0] TOK_EP1_OUT = 8'hFF;

  typedef enum logic [2:0] {PK_NONE, PK_TOK_SO, PK_TOK_IN, PK_DATA, PK_OTHER} pkt_class_e;
  typedef enum logic [1:0] {RP_NONE, RP_HS, RP_BUF} reply_e;

  // a length field with bit 4 set carries a handshake PID
  function automatic logic field_is_handshake(input logic [7:0] f);
    return f[4];
  endfunction

  // IN endpoint index from the token bytes
  function automatic logic [1:0] in_ep_index(input logic [7:0] b1, input logic [7:0] b2);
    if (!b1[7]) return 2'd0;
    return b2[0] ? 2'd2 : 2'd1;
  endfunction

  // receive area still holds unprocessed data
  function automatic logic rx_pending(input logic [7:0] l);
    return $signed(l) > 8'sd0;
  endfunction
endpackage

// File: rtl/usbtr_classify.sv
module usbtr_classify
  import usbtr_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int ADDR_W = 7,
  parameter int MIN_TOKEN_LEN = 3
) (
  input  logic [LEN_W-1:0]  len,
  input  logic [7:0]        pid,
  input  logic [7:0]        byte1,
  input  logic [ADDR_W-1:0] dev_addr,
  output pkt_class_e        kind,
  output logic              addr_hit
);
  always_comb begin
    if (len < LEN_W'(MIN_TOKEN_LEN)) kind = PK_NONE;
    else if (pid == PID_DATA0 || pid == PID_DATA1) kind = PK_DATA;
    else if (pid == PID_SETUP || pid == PID_OUT) kind = PK_TOK_SO;
    else if (pid == PID_IN) kind = PK_TOK_IN;
    else kind = PK_OTHER;
  end

  assign addr_hit = (byte1[ADDR_W-1:0] == dev_addr);
endmodule

// File: rtl/usbtr_dispatch.sv
module usbtr_dispatch
  import usbtr_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int MIN_STORE_LEN = 4
) (
  input  pkt_class_e       kind,
  input  logic             addr_hit,
  input  logic [7:0]       pid,
  input  logic [7:0]       byte1,
  input  logic [LEN_W-1:0] len,
  input  logic [7:0]       cur_tok,
  input  logic [7:0]       rx_len_q,
  input  logic [7:0]       ep_field,
  output reply_e           reply,
  output logic [7:0]       reply_pid,
  output logic             cur_we,
  output logic [7:0]       cur_new,
  output logic             store,
  output logic             field_clear
);
  always_comb begin
    reply = RP_NONE;
    reply_pid = 8'h00;
    cur_we = 1'b0;
    cur_new = 8'h00;
    store = 1'b0;
    field_clear = 1'b0;
    unique case (kind)
      PK_TOK_SO: begin
        cur_we = 1'b1;
        if (!addr_hit) cur_new = 8'h00;
        else if (pid == PID_OUT && byte1[7]) cur_new = TOK_EP1_OUT;
        else cur_new = pid;
      end
      PK_TOK_IN: begin
        if (!addr_hit) begin
          cur_we = 1'b1;
        end else if (rx_pending(rx_len_q)) begin
          reply = RP_HS;
          reply_pid = PID_NAK;
        end else if (field_is_handshake(ep_field)) begin
          reply = RP_HS;
          reply_pid = ep_field;
        end else begin
          reply = RP_BUF;
          field_clear = 1'b1;
        end
      end
      PK_DATA: begin
        if (cur_tok != 8'h00) begin
          reply = RP_HS;
          if (rx_pending(rx_len_q)) reply_pid = PID_NAK;
          else begin
            reply_pid = PID_ACK;
            store = (len >= LEN_W'(MIN_STORE_LEN));
          end
        end
      end
      PK_OTHER: cur_we = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/usbtr_txlen_bank.sv
module usbtr_txlen_bank
  import usbtr_pkg::*;
#(
  parameter int N_EP = 3,
  parameter int SEL_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr,
  input  logic [SEL_W-1:0]      wr_sel,
  input  logic [7:0]            wr_data,
  input  logic                  clr,
  input  logic [SEL_W-1:0]      clr_sel,
  output logic [N_EP-1:0][7:0]  fields
);
  for (genvar i = 0; i < N_EP; i++) begin : g_ep
    logic clr_hit;
    assign clr_hit = clr && (clr_sel == SEL_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n) fields[i] <= PID_NAK;
      else if (clr_hit) fields[i] <= PID_NAK;
      else if (wr && wr_sel == SEL_W'(i)) fields[i] <= wr_data;
    end
    // R10: a sent buffer leaves its field at NAK
    a_r10_field_back_to_nak: assert property (@(posedge clk) disable iff (!rst_n)
      clr_hit |=> fields[i] == PID_NAK);
  end
endmodule

// File: rtl/usbtr_addr_ctrl.sv
module usbtr_addr_ctrl #(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_wr,
  input  logic [ADDR_W-1:0] addr_wdata,
  input  logic              req_buf,
  input  logic              req_hs,
  input  logic              tx_done,
  output logic [ADDR_W-1:0] dev_addr
);
  logic [ADDR_W-1:0] pend_addr;
  logic              pend_vld;
  logic              last_buf;
  logic              apply_ev;

  assign apply_ev = tx_done && last_buf && pend_vld;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_addr <= '0;
      pend_vld <= 1'b0;
      last_buf <= 1'b0;
      dev_addr <= '0;
    end else begin
      if (req_buf) last_buf <= 1'b1;
      else if (req_hs || tx_done) last_buf <= 1'b0;
      if (addr_wr) begin
        pend_addr <= addr_wdata;
        pend_vld <= 1'b1;
      end else if (apply_ev) begin
        pend_vld <= 1'b0;
      end
      if (apply_ev) dev_addr <= pend_addr;
    end
  end

  // R12: the address moves only at the end of a buffer transmission
  a_r12_addr_after_buffer: assert property (@(posedge clk) disable iff (!rst_n)
    dev_addr != $past(dev_addr) |-> $past(tx_done) && $past(last_buf));
endmodule

// File: rtl/usb_token_responder.sv
module usb_token_responder
  import usbtr_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int ADDR_W = 7,
  parameter int N_EP = 3,
  parameter int MIN_TOKEN_LEN = 3,
  parameter int MIN_STORE_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [LEN_W-1:0]  rx_len,
  input  logic [7:0]        rx_pid,
  input  logic [7:0]        rx_byte1,
  input  logic [7:0]        rx_byte2,
  input  logic              txlen_wr,
  input  logic [1:0]        txlen_sel,
  input  logic [7:0]        txlen_wdata,
  input  logic              rx_len_wr,
  input  logic [7:0]        rx_len_wdata,
  input  logic              addr_wr,
  input  logic [ADDR_W-1:0] addr_wdata,
  input  logic              tx_done,
  output logic              tx_req,
  output logic              tx_is_buf,
  output logic [7:0]        tx_pid,
  output logic [1:0]        tx_buf_sel,
  output logic [7:0]        tx_buf_len,
  output logic [7:0]        rx_data_len,
  output logic [7:0]        rx_data_tok,
  output logic              rx_half,
  output logic [ADDR_W-1:0] dev_addr,
  output logic [7:0]        cur_tok
);
  localparam int SEL_W = 2;

  pkt_class_e          kind;
  logic                addr_hit;
  logic [SEL_W-1:0]    ep_sel;
  logic [N_EP-1:0][7:0] fields;
  logic [7:0]          ep_field;
  reply_e              reply;
  logic [7:0]          reply_pid;
  logic                cur_we, store, field_clear;
  logic [7:0]          cur_new;
  // named dispatch events
  logic                ev_store, ev_cur, ev_clear, ev_req_buf, ev_req_hs;

  assign ep_sel = in_ep_index(rx_byte1, rx_byte2);
  assign ep_field = (int'(ep_sel) < N_EP) ? fields[ep_sel] : PID_NAK;

  usbtr_classify #(.LEN_W(LEN_W), .ADDR_W(ADDR_W), .MIN_TOKEN_LEN(MIN_TOKEN_LEN)) u_cls (
    .len(rx_len), .pid(rx_pid), .byte1(rx_byte1), .dev_addr(dev_addr),
    .kind(kind), .addr_hit(addr_hit));

  usbtr_dispatch #(.LEN_W(LEN_W), .MIN_STORE_LEN(MIN_STORE_LEN)) u_dsp (
    .kind(kind), .addr_hit(addr_hit), .pid(rx_pid), .byte1(rx_byte1), .len(rx_len),
    .cur_tok(cur_tok), .rx_len_q(rx_data_len), .ep_field(ep_field),
    .reply(reply), .reply_pid(reply_pid), .cur_we(cur_we), .cur_new(cur_new),
    .store(store), .field_clear(field_clear));

  assign ev_store   = rx_valid && store;
  assign ev_cur     = rx_valid && cur_we;
  assign ev_clear   = rx_valid && field_clear;
  assign ev_req_buf = tx_req && tx_is_buf;
  assign ev_req_hs  = tx_req && !tx_is_buf;

  usbtr_txlen_bank #(.N_EP(N_EP), .SEL_W(SEL_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr(txlen_wr), .wr_sel(txlen_sel), .wr_data(txlen_wdata),
    .clr(ev_clear), .clr_sel(ep_sel), .fields(fields));

  usbtr_addr_ctrl #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .addr_wr(addr_wr), .addr_wdata(addr_wdata),
    .req_buf(ev_req_buf), .req_hs(ev_req_hs), .tx_done(tx_done), .dev_addr(dev_addr));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_req <= 1'b0;
      tx_is_buf <= 1'b0;
      tx_pid <= 8'h00;
      tx_buf_sel <= '0;
      tx_buf_len <= 8'h00;
      cur_tok <= 8'h00;
      rx_data_len <= 8'h00;
      rx_data_tok <= 8'h00;
      rx_half <= 1'b0;
    end else begin
      tx_req <= rx_valid && (reply != RP_NONE);
      if (rx_valid && reply != RP_NONE) begin
        tx_is_buf <= (reply == RP_BUF);
        tx_pid <= reply_pid;
        tx_buf_sel <= ep_sel;
        tx_buf_len <= ep_field;
      end
      if (ev_cur) cur_tok <= cur_new;
      if (ev_store) begin
        rx_data_len <= 8'(rx_len);
        rx_data_tok <= cur_tok;
        rx_half <= ~rx_half;
      end else if (rx_len_wr) begin
        rx_data_len <= rx_len_wdata;
      end
    end
  end

  // R11: every request answers the packet of the previous cycle
  a_r11_req_after_packet: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |-> $past(rx_valid));
  // R11: the request is a single pulse
  a_r11_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |=> !tx_req);
  // R10: handshake requests always carry a PID with bit 4 set
  a_r10_hs_pid_form: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && !tx_is_buf) |-> tx_pid[4]);
  // R7: the buffer half changes only when a packet was taken in
  a_r7_half_on_packet: assert property (@(posedge clk) disable iff (!rst_n)
    rx_half != $past(rx_half) |-> $past(rx_valid));
  // R9: no buffer index beyond the endpoint count
  a_r9_sel_range: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && tx_is_buf) |-> int'(tx_buf_sel) < N_EP);
endmodule

// File: tb/sim_usb_token_responder.sv
module sim_usb_token_responder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 0;
  logic [7:0] rx_len = 0, rx_pid = 0, rx_byte1 = 0, rx_byte2 = 0;
  logic txlen_wr = 0;
  logic [1:0] txlen_sel = 0;
  logic [7:0] txlen_wdata = 0;
  logic rx_len_wr = 0;
  logic [7:0] rx_len_wdata = 0;
  logic addr_wr = 0;
  logic [6:0] addr_wdata = 0;
  logic tx_done = 0;
  logic tx_req, tx_is_buf, rx_half;
  logic [7:0] tx_pid, tx_buf_len, rx_data_len, rx_data_tok, cur_tok;
  logic [1:0] tx_buf_sel;
  logic [6:0] dev_addr;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  usb_token_responder u0 (.*);

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  // drive one packet summary; returns at the negedge where the reply is visible
  task automatic pkt(input logic [7:0] pid, input logic [7:0] len,
                     input logic [7:0] b1, input logic [7:0] b2);
    rx_valid = 1; rx_pid = pid; rx_len = len; rx_byte1 = b1; rx_byte2 = b2;
    tick();
    rx_valid = 0;
  endtask

  task automatic expect_none(input string tag);
    chk({tag, " no reply"}, tx_req, 0);
    tick();
  endtask

  task automatic expect_hs(input string tag, input logic [7:0] pid);
    chk({tag, " req"}, tx_req, 1);
    chk({tag, " handshake kind"}, tx_is_buf, 0);
    chk({tag, " pid"}, tx_pid, pid);
    tick();
    chk({tag, " R11 single pulse"}, tx_req, 0);
  endtask

  task automatic expect_buf(input string tag, input int sel, input int len);
    chk({tag, " req"}, tx_req, 1);
    chk({tag, " buffer kind"}, tx_is_buf, 1);
    chk({tag, " sel"}, tx_buf_sel, sel);
    chk({tag, " len"}, tx_buf_len, len);
    tick();
    chk({tag, " R11 single pulse"}, tx_req, 0);
  endtask

  task automatic wr_txlen(input int sel, input logic [7:0] v);
    txlen_wr = 1; txlen_sel = 2'(sel); txlen_wdata = v; tick(); txlen_wr = 0;
  endtask

  task automatic free_rx();
    rx_len_wr = 1; rx_len_wdata = 0; tick(); rx_len_wr = 0;
  endtask

  task automatic done_pulse();
    tx_done = 1; tick(); tx_done = 0;
  endtask

  task automatic t_reset();
    chk("R1 tx_req", tx_req, 0);
    chk("R1 dev_addr", dev_addr, 0);
    chk("R1 cur_tok", cur_tok, 0);
    chk("R1 rx_data_len", rx_data_len, 0);
    chk("R1 rx_data_tok", rx_data_tok, 0);
    chk("R1 rx_half", rx_half, 0);
    pkt(8'h69, 3, 8'h00, 8'h00);
    expect_hs("R1 field0 resets to NAK", 8'h5A);
  endtask

  task automatic t_tokens();
    pkt(8'h2D, 3, 8'h00, 8'h00); expect_none("R3 setup");
    chk("R3 cur_tok setup", cur_tok, 8'h2D);
    pkt(8'h2D, 3, 8'h05, 8'h00); expect_none("R2 mismatch");
    chk("R2 cur_tok cleared", cur_tok, 0);
    pkt(8'hE1, 3, 8'h80, 8'h00); expect_none("R3 out ep1");
    chk("R3 cur_tok ep1 marker", cur_tok, 8'hFF);
    pkt(8'hE1, 3, 8'h00, 8'h00);
    chk("R3 cur_tok out", cur_tok, 8'hE1);
    tick();
    pkt(8'hD2, 2, 8'h00, 8'h00); expect_none("R13 short");
    chk("R13 cur_tok kept", cur_tok, 8'hE1);
    pkt(8'hA5, 3, 8'h00, 8'h00); expect_none("R13 other pid");
    chk("R13 cur_tok cleared", cur_tok, 0);
  endtask

  task automatic t_data();
    pkt(8'hC3, 10, 8'h00, 8'h00); expect_none("R4 data without token");
    chk("R4 len unchanged", rx_data_len, 0);
    chk("R4 half unchanged", rx_half, 0);
    pkt(8'h2D, 3, 8'h00, 8'h00); tick();
    pkt(8'hC3, 3, 8'h00, 8'h00); expect_hs("R6 zero length", 8'hD2);
    chk("R6 len unchanged", rx_data_len, 0);
    chk("R6 half unchanged", rx_half, 0);
    pkt(8'hC3, 11, 8'h00, 8'h00); expect_hs("R7 store", 8'hD2);
    chk("R7 len", rx_data_len, 11);
    chk("R7 tok", rx_data_tok, 8'h2D);
    chk("R7 half", rx_half, 1);
    pkt(8'h4B, 5, 8'h00, 8'h00); expect_hs("R5 busy", 8'h5A);
    chk("R5 len kept", rx_data_len, 11);
    chk("R5 half kept", rx_half, 1);
    pkt(8'h69, 3, 8'h00, 8'h00); expect_hs("R8 in busy", 8'h5A);
    free_rx();
    pkt(8'hE1, 3, 8'h80, 8'h00); tick();
    pkt(8'h4B, 6, 8'h00, 8'h00); expect_hs("R7 ep1 store", 8'hD2);
    chk("R7 ep1 tok", rx_data_tok, 8'hFF);
    chk("R7 half back", rx_half, 0);
    chk("R7 ep1 len", rx_data_len, 6);
    free_rx();
  endtask

  task automatic t_in();
    wr_txlen(0, 8'h1E);
    pkt(8'h69, 3, 8'h00, 8'h00); expect_hs("R10 parked stall", 8'h1E);
    wr_txlen(1, 8'd9);
    pkt(8'h69, 3, 8'h80, 8'h00); expect_buf("R9 ep1 buffer", 1, 9);
    pkt(8'h69, 3, 8'h80, 8'h00); expect_hs("R10 ep1 back to NAK", 8'h5A);
    wr_txlen(2, 8'd4);
    pkt(8'h69, 3, 8'h80, 8'h01); expect_buf("R9 ep2 buffer", 2, 4);
    pkt(8'h69, 3, 8'h00, 8'h00); expect_hs("R10 ep0 stall kept", 8'h1E);
  endtask

  task automatic t_addr();
    addr_wr = 1; addr_wdata = 7'h23; tick(); addr_wr = 0;
    chk("R12 not yet", dev_addr, 0);
    pkt(8'h69, 3, 8'h00, 8'h00); expect_hs("R12 handshake", 8'h1E);
    done_pulse();
    chk("R12 after handshake", dev_addr, 0);
    wr_txlen(0, 8'd2);
    pkt(8'h69, 3, 8'h00, 8'h00); expect_buf("R12 buffer", 0, 2);
    chk("R12 before done", dev_addr, 0);
    done_pulse();
    chk("R12 applied", dev_addr, 7'h23);
    pkt(8'h2D, 3, 8'h00, 8'h00); expect_none("R2 old address");
    chk("R2 old address cur_tok", cur_tok, 0);
    pkt(8'h2D, 3, 8'h23, 8'h00); expect_none("R3 new address");
    chk("R3 new address cur_tok", cur_tok, 8'h2D);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; tick();
    t_reset();
    t_tokens();
    t_data();
    t_in();
    t_addr();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule